// File: doc/BRIEF.md
# ASID-Tagged Micro Translation Buffer

This block holds the most recent virtual-to-physical translations for one access side of a processor (either instruction fetch or data access) in a small fully associative array. A lookup presents a virtual address together with the address space identifier of the running process. In the same cycle the block reports a hit and returns the physical address, the page size and the stored protection bits. A separate permission checker uses those bits. On a miss, the miss flag asks the next translation level (a shared second-level buffer or the table walker) for the translation. That level later writes the result through the fill port.

Every entry carries the identifier of the address space that owns it. Entries from several processes can therefore stay resident together, and a context switch needs no flush. An entry marked global is shared by all address spaces and matches any identifier. Each entry records one of four page sizes, and the tag compare ignores the address bits inside the page. A full array makes room by evicting in rotation order, or by a pseudo-random pick that a mode input selects. Software-driven maintenance can clear the whole array, clear one address space while keeping global entries, or clear whatever maps one virtual page.

Top module: `micro_tlb`

## Requirements
- R1: The array holds 32 entries, fully associative. Any 32 distinct translations filled into an empty array all hit afterwards.
- R2: A lookup is answered combinationally. `lk_hit` and `lk_pa` are valid in the same cycle that `lk_valid` is high.
- R3: A non-global entry hits only when its stored identifier equals `lk_asid`.
- R4: A global entry (`fl_global`=1 at fill) hits for every value of `lk_asid`.
- R5: On a hit, `lk_prot` and `lk_size` equal the protection bits and size code stored with the matching entry.
- R6: `lk_miss` is high exactly when `lk_valid` is high and no entry matches. A translation written through the fill port is visible to lookups from the next cycle on.
- R7: The size codes are 0=4 KB, 1=64 KB, 2=1 MB and 3=16 MB. The tag compare ignores the 0, 4, 8 or 12 low page-number bits that lie inside the page. `lk_pa` takes the bits above the page offset from the stored frame number and the offset bits from `lk_va`.
- R8: A fill goes to the lowest-numbered empty slot. When the array is full and `repl_random`=0, victims are taken in rotation starting at slot 0, so the oldest of 32 in-order fills is evicted first.
- R9: When the array is full and `repl_random`=1, the victim comes from a free-running LFSR. Exactly one resident entry is displaced and the new entry hits.
- R10: `inv_all` empties the whole array in one cycle.
- R11: `inv_asid` removes the non-global entries whose identifier equals `inv_asid_val`. Global entries and other identifiers are kept.
- R12: `inv_va` removes every entry, of any identifier, whose page covers page number `inv_va_vpn`.
- R13: When a fill and a lookup happen in the same cycle, the lookup sees the contents from before the fill.
- R14: After reset no entry is valid. While `lk_valid` is low, both `lk_hit` and `lk_miss` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| repl_random | input | 1 | 1 = pseudo-random victim choice, 0 = rotation |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Identifier of the running address space |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup found no entry; request goes to the next level |
| lk_pa | output | 32 | Translated physical address |
| lk_prot | output | 8 | Stored protection/attribute bits of the hit |
| lk_size | output | 2 | Size code of the hit |
| fl_valid | input | 1 | Write a translation |
| fl_vpn | input | 20 | Virtual page number of the fill |
| fl_asid | input | 8 | Owning identifier of the fill |
| fl_global | input | 1 | Fill is shared by all identifiers |
| fl_size | input | 2 | Size code of the fill |
| fl_ppn | input | 20 | Physical frame number of the fill |
| fl_prot | input | 8 | Protection/attribute bits of the fill |
| inv_all | input | 1 | Clear every entry |
| inv_asid | input | 1 | Clear the non-global entries of one identifier |
| inv_asid_val | input | 8 | Identifier for `inv_asid` |
| inv_va | input | 1 | Clear the entries covering one page |
| inv_va_vpn | input | 20 | Page number for `inv_va` |

## Verification
The assertions check some properties on every cycle: hit and miss are exclusive and complete while a lookup is active, and both stay low when it is not. A full clear leaves no valid slot. A fill into a non-full array adds exactly one valid slot, and a fill into a full array keeps it full. The scenarios are needed for everything that depends on stored content. These are identifier and global matching, masking at the four page sizes, address splicing, the selective clears, the rotation order of evictions, the count of survivors after a random eviction, and a lookup that coincides with a fill.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int ASID_W = 8;
    localparam int PROT_W = 8;
    localparam int SIZE_STEP = 4;   // page-number bits added per size code

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic              vld;
        logic              glb;
        logic [ASID_W-1:0] asid;
        pg_size_e          size;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
    } tlb_ent_t;

    // Ones on the page-number bits that lie inside a page of the given size
    function automatic logic [VPN_W-1:0] size_mask(pg_size_e s);
        logic [VPN_W-1:0] m;
        for (int b = 0; b < VPN_W; b++) begin
            m[b] = (b < SIZE_STEP * int'(s));
        end
        return m;
    endfunction
endpackage

// File: rtl/mtlb_match.sv
module mtlb_match
    import mtlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  logic              any_asid,
    output logic              hit
);
    logic [VPN_W-1:0] ofs_mask;
    logic             tag_eq;
    logic             asid_ok;

    always_comb begin
        ofs_mask = size_mask(ent.size);
        tag_eq   = (((ent.vpn ^ vpn) & ~ofs_mask) == '0);
        asid_ok  = any_asid | ent.glb | (ent.asid == asid);
        hit      = ent.vld & tag_eq & asid_ok;
    end
endmodule

// File: rtl/mtlb_victim.sv
module mtlb_victim #(
    parameter int                ENTRIES = 32,
    parameter int                IDX_W   = $clog2(ENTRIES),
    parameter int                LFSR_W  = 16,
    parameter logic [LFSR_W-1:0] SEED    = 'hACE1,
    parameter logic [LFSR_W-1:0] TAPS    = 'hB400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld,
    input  logic               fill,
    input  logic               rand_mode,
    output logic [IDX_W-1:0]   victim
);
    typedef struct packed {
        logic [IDX_W-1:0]  rr;
        logic [LFSR_W-1:0] lf;
    } vst_t;

    vst_t             st_d, st_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rnd_idx;

    always_comb begin
        st_d = st_q;
        // free-running Galois LFSR
        st_d.lf = st_q.lf >> 1;
        if (st_q.lf[0]) st_d.lf = st_d.lf ^ TAPS;

        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        rnd_idx = IDX_W'(int'(st_q.lf[IDX_W-1:0]) % ENTRIES);

        if (free_found)     victim = free_idx;
        else if (rand_mode) victim = rnd_idx;
        else                victim = st_q.rr;

        if (fill && !free_found && !rand_mode) begin
            st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rr <= '0;
            st_q.lf <= SEED;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/micro_tlb.sv
module micro_tlb
    import mtlb_pkg::*;
#(
    parameter int                ENTRIES   = 32,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 'hACE1,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              repl_random,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [VA_W-1:0]   lk_pa,
    output logic [PROT_W-1:0] lk_prot,
    output logic [1:0]        lk_size,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_global,
    input  logic [1:0]        fl_size,
    input  logic [VPN_W-1:0]  fl_ppn,
    input  logic [PROT_W-1:0] fl_prot,
    input  logic              inv_all,
    input  logic              inv_asid,
    input  logic [ASID_W-1:0] inv_asid_val,
    input  logic              inv_va,
    input  logic [VPN_W-1:0]  inv_va_vpn
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
    } st_t;

    st_t                st_d, st_q;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] iv_match;
    logic [ENTRIES-1:0] vld_vec;
    logic [IDX_W-1:0]   victim;
    tlb_ent_t           sel;
    logic               any_hit;
    logic [VPN_W-1:0]   sel_mask;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign vld_vec[i] = st_q.ent[i].vld;

        mtlb_match u_lk_cmp (
            .ent      (st_q.ent[i]),
            .vpn      (lk_va[VA_W-1:OFS_W]),
            .asid     (lk_asid),
            .any_asid (1'b0),
            .hit      (lk_match[i])
        );

        mtlb_match u_iv_cmp (
            .ent      (st_q.ent[i]),
            .vpn      (inv_va_vpn),
            .asid     ('0),
            .any_asid (1'b1),
            .hit      (iv_match[i])
        );
    end

    mtlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .LFSR_W  (LFSR_W),
        .SEED    (LFSR_SEED),
        .TAPS    (LFSR_TAPS)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (vld_vec),
        .fill      (fl_valid),
        .rand_mode (repl_random),
        .victim    (victim)
    );

    // Lookup path: reads only registered contents
    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i] && !any_hit) begin
                any_hit = 1'b1;
                sel     = st_q.ent[i];
            end
        end
        lk_hit   = lk_valid & any_hit;
        lk_miss  = lk_valid & ~any_hit;
        sel_mask = size_mask(sel.size);
        lk_pa    = {(sel.ppn & ~sel_mask) | (lk_va[VA_W-1:OFS_W] & sel_mask),
                    lk_va[OFS_W-1:0]};
        lk_prot  = sel.prot;
        lk_size  = sel.size;
    end

    // Next contents: invalidations act on the old array, a fill lands after them
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (inv_all) st_d.ent[i].vld = 1'b0;
            if (inv_asid && !st_q.ent[i].glb && (st_q.ent[i].asid == inv_asid_val))
                st_d.ent[i].vld = 1'b0;
            if (inv_va && iv_match[i]) st_d.ent[i].vld = 1'b0;
        end
        if (fl_valid) begin
            st_d.ent[victim] = '{vld:  1'b1,
                                 glb:  fl_global,
                                 asid: fl_asid,
                                 size: pg_size_e'(fl_size),
                                 vpn:  fl_vpn,
                                 ppn:  fl_ppn,
                                 prot: fl_prot};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit ^ lk_miss));

    // R14
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    // R10
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fl_valid) |=> (vld_vec == '0));

    // R8
    fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !(&vld_vec) && !inv_all && !inv_asid && !inv_va)
        |=> ($countones(vld_vec) == $past($countones(vld_vec)) + 1));

    // R9
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && (&vld_vec) && !inv_all && !inv_asid && !inv_va) |=> (&vld_vec));
endmodule

// File: tb/test_micro_tlb.sv
module test_micro_tlb;
    import mtlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              repl_random;
    logic              lk_valid;
    logic [VA_W-1:0]   lk_va;
    logic [ASID_W-1:0] lk_asid;
    logic              lk_hit, lk_miss;
    logic [VA_W-1:0]   lk_pa;
    logic [PROT_W-1:0] lk_prot;
    logic [1:0]        lk_size;
    logic              fl_valid;
    logic [VPN_W-1:0]  fl_vpn;
    logic [ASID_W-1:0] fl_asid;
    logic              fl_global;
    logic [1:0]        fl_size;
    logic [VPN_W-1:0]  fl_ppn;
    logic [PROT_W-1:0] fl_prot;
    logic              inv_all, inv_asid, inv_va;
    logic [ASID_W-1:0] inv_asid_val;
    logic [VPN_W-1:0]  inv_va_vpn;

    always #10 clk = ~clk;   // 50 MHz

    micro_tlb i_micro_tlb (.*);

    typedef struct {
        bit          care;
        bit          hit;
        logic [31:0] pa;
        logic [7:0]  prot;
        logic [1:0]  size;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad   = 0;
    logic last_hit;
    bit   done = 1'b0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per active lookup
    always @(negedge clk) begin
        if (rst_n && lk_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", 32'd0, 32'd1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                last_hit = lk_hit;
                if (e.care) begin
                    total++;
                    if (!e.hit ? (lk_hit !== 1'b0 || lk_miss !== 1'b1)
                               : (lk_hit !== 1'b1 || lk_miss !== 1'b0 || lk_pa !== e.pa ||
                                  lk_prot !== e.prot || lk_size !== e.size)) begin
                        bad++;
                        $display("FAIL %s: hit=%0b pa=%h prot=%h size=%0d expected hit=%0b pa=%h prot=%h size=%0d",
                                 e.tag, lk_hit, lk_pa, lk_prot, lk_size, e.hit, e.pa, e.prot, e.size);
                    end
                end
            end
        end
    end

    task automatic clr();
        lk_valid = 1'b0; fl_valid = 1'b0;
        inv_all = 1'b0; inv_asid = 1'b0; inv_va = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        clr();
    endtask

    task automatic drive_look(logic [31:0] va, logic [7:0] asid);
        lk_valid = 1'b1; lk_va = va; lk_asid = asid;
    endtask

    task automatic look(logic [31:0] va, logic [7:0] asid, bit h, logic [31:0] pa,
                        logic [7:0] prot, logic [1:0] size, string tag);
        step();
        drive_look(va, asid);
        sb_q.push_back('{care: 1'b1, hit: h, pa: pa, prot: prot, size: size, tag: tag});
    endtask

    task automatic miss(logic [31:0] va, logic [7:0] asid, string tag);
        look(va, asid, 1'b0, 32'd0, 8'd0, 2'd0, tag);
    endtask

    task automatic probe(logic [31:0] va, logic [7:0] asid, output logic h);
        step();
        drive_look(va, asid);
        sb_q.push_back('{care: 1'b0, hit: 1'b0, pa: 32'd0, prot: 8'd0, size: 2'd0, tag: "probe"});
        @(negedge clk);
        #1;
        h = last_hit;
    endtask

    task automatic drive_fill(logic [19:0] vpn, logic [7:0] asid, logic glb, logic [1:0] size,
                              logic [19:0] ppn, logic [7:0] prot);
        fl_valid = 1'b1; fl_vpn = vpn; fl_asid = asid; fl_global = glb;
        fl_size = size; fl_ppn = ppn; fl_prot = prot;
    endtask

    task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic glb, logic [1:0] size,
                        logic [19:0] ppn, logic [7:0] prot);
        step();
        drive_fill(vpn, asid, glb, size, ppn, prot);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic h;
        int   n;
        clr();
        repl_random = 1'b0; rst_n = 1'b0;
        lk_va = '0; lk_asid = '0; fl_vpn = '0; fl_asid = '0; fl_global = 1'b0;
        fl_size = '0; fl_ppn = '0; fl_prot = '0; inv_asid_val = '0; inv_va_vpn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(lk_hit == 1'b0 && lk_miss == 1'b0, "R14 idle during reset", {30'd0, lk_hit, lk_miss}, 32'd0);
        rst_n = 1'b1;

        miss(32'h1234_5678, 8'd3, "R14 empty after reset");

        // basic 4 KB entry, same-cycle answer
        fill(20'h12345, 8'd3, 1'b0, 2'd0, 20'hABCDE, 8'h5A);
        look(32'h1234_5678, 8'd3, 1'b1, 32'hABCD_E678, 8'h5A, 2'd0, "R2 R5 R6 4KB hit");
        miss(32'h1234_5678, 8'd4, "R3 other asid");

        // global 1 MB entry, low page bits ignored
        fill(20'h400FF, 8'd1, 1'b1, 2'd2, 20'h800CC, 8'h11);
        look(32'h400A_B123, 8'd9, 1'b1, 32'h800A_B123, 8'h11, 2'd2, "R4 R7 1MB global");
        look(32'h400A_B123, 8'd0, 1'b1, 32'h800A_B123, 8'h11, 2'd2, "R4 global asid0");

        // 64 KB entry
        fill(20'h00510, 8'd3, 1'b0, 2'd1, 20'h07770, 8'h22);
        look(32'h0051_F00C, 8'd3, 1'b1, 32'h0777_F00C, 8'h22, 2'd1, "R7 64KB");
        miss(32'h0052_0000, 8'd3, "R7 64KB outside page");

        // 16 MB entry
        fill(20'hA0000, 8'd5, 1'b0, 2'd3, 20'h30000, 8'h33);
        look(32'hA0FF_FFFC, 8'd5, 1'b1, 32'h30FF_FFFC, 8'h33, 2'd3, "R7 16MB");
        miss(32'hA0FF_FFFC, 8'd6, "R3 16MB other asid");

        // fill and lookup in the same cycle
        step();
        drive_fill(20'h77777, 8'd3, 1'b0, 2'd0, 20'h01234, 8'h44);
        drive_look(32'h7777_7ABC, 8'd3);
        sb_q.push_back('{care: 1'b1, hit: 1'b0, pa: 32'd0, prot: 8'd0, size: 2'd0, tag: "R13 fill same cycle"});
        look(32'h7777_7ABC, 8'd3, 1'b1, 32'h0123_4ABC, 8'h44, 2'd0, "R6 R13 visible next cycle");

        // clear by identifier
        step();
        inv_asid = 1'b1; inv_asid_val = 8'd3;
        miss(32'h1234_5678, 8'd3, "R11 asid entry cleared");
        miss(32'h0051_F00C, 8'd3, "R11 64KB cleared");
        miss(32'h7777_7ABC, 8'd3, "R11 third cleared");
        look(32'h400A_B123, 8'd3, 1'b1, 32'h800A_B123, 8'h11, 2'd2, "R11 global kept");
        look(32'hA0FF_FFFC, 8'd5, 1'b1, 32'h30FF_FFFC, 8'h33, 2'd3, "R11 other asid kept");

        // clear by page
        step();
        inv_va = 1'b1; inv_va_vpn = 20'h400AB;
        miss(32'h400A_B123, 8'd7, "R12 covering page cleared");
        look(32'hA0FF_FFFC, 8'd5, 1'b1, 32'h30FF_FFFC, 8'h33, 2'd3, "R12 other page kept");
        fill(20'h33333, 8'd9, 1'b0, 2'd0, 20'h44444, 8'h55);
        step();
        inv_va = 1'b1; inv_va_vpn = 20'h33333;
        miss(32'h3333_3000, 8'd9, "R12 any asid");

        // clear all
        step();
        inv_all = 1'b1;
        miss(32'hA0FF_FFFC, 8'd5, "R10 all cleared");

        // capacity and rotation
        for (int i = 0; i < 32; i++)
            fill(20'h10000 + 20'(i), 8'd1, 1'b0, 2'd0, 20'h20000 + 20'(i), 8'(i));
        for (int i = 0; i < 32; i++)
            look({20'h10000 + 20'(i), 12'h010}, 8'd1, 1'b1, {20'h20000 + 20'(i), 12'h010},
                 8'(i), 2'd0, "R1 32 resident");
        fill(20'h50000, 8'd1, 1'b0, 2'd0, 20'h50000, 8'h99);
        miss(32'h1000_0000, 8'd1, "R8 oldest evicted");
        look(32'h1000_1000, 8'd1, 1'b1, 32'h2000_1000, 8'h01, 2'd0, "R8 second kept");
        look(32'h5000_0000, 8'd1, 1'b1, 32'h5000_0000, 8'h99, 2'd0, "R8 new resident");
        fill(20'h50001, 8'd1, 1'b0, 2'd0, 20'h50001, 8'h98);
        miss(32'h1000_1000, 8'd1, "R8 rotation next");
        look(32'h1000_2000, 8'd1, 1'b1, 32'h2000_2000, 8'h02, 2'd0, "R8 third kept");

        // pseudo-random replacement
        step();
        repl_random = 1'b1;
        fill(20'h60000, 8'd1, 1'b0, 2'd0, 20'h60000, 8'h77);
        look(32'h6000_0000, 8'd1, 1'b1, 32'h6000_0000, 8'h77, 2'd0, "R9 new hits");
        n = 0;
        for (int i = 2; i < 32; i++) begin
            probe({20'h10000 + 20'(i), 12'h000}, 8'd1, h);
            if (h) n++;
        end
        probe(32'h5000_0000, 8'd1, h); if (h) n++;
        probe(32'h5000_1000, 8'd1, h); if (h) n++;
        check(n == 31, "R9 one displaced", 32'(n), 32'd31);

        step();
        repeat (2) @(posedge clk);
        check(sb_q.size() == 0, "R2 scoreboard drained", 32'(sb_q.size()), 32'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule